// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block is a byte-wide timer with three independent 16-bit down-counters. A two-bit address selects either one channel's data register (addresses 0, 1 and 2) or the shared control register (address 3). A control byte does one of three things. It configures one channel's access mode and operating mode. It freezes one channel's count. Or it issues a read-back command that freezes count and status for any set of channels at once. Reload values are written one byte at a time, following the byte sequence chosen by the access mode. A read returns the live count, a frozen count or a frozen status byte.

Each channel has a gate input and an output pin. It counts on a shared count-enable pulse that stands for the slow timer clock. Three operating modes are implemented: interrupt on terminal count (mode 0), rate generator (mode 2) and square wave (mode 3). The other mode codes are stored and reported in status, but their channels never count. Channel 0's output feeds the interrupt request line. BCD counting is not done: the BCD flag is stored and reported in status only.

Top module: `pit3_timer`

## Requirements
- R1: A control byte is decoded as follows. Bits 7:6 select the channel, and 3 in that field means read-back. Bits 5:4 are the access mode: 0 freezes the count, 1 is low byte only, 2 is high byte only, 3 is low then high. Bits 3:1 are the operating mode and bit 0 is the BCD flag. Reading address 3 returns 8'h00.
- R2: Data writes follow the access mode. Low-only loads {8'h00,byte}. High-only loads {byte,8'h00}. Low-then-high takes the low byte first and the high byte second, and only the second byte completes the value. Live reads in low-only or high-only mode return the matching byte of the count. A data write to a channel that has never been configured is ignored.
- R3: A configuring control write drives the channel output low for mode 0 and high for every other mode, from the next clock.
- R4: The status null-count flag (bit 6) is set when a reload value is completed. It is cleared at the next count pulse, which moves that value into the counter.
- R5: Mode 0: the output stays low while counting. It goes high on the N-th count pulse after the load and then stays high.
- R6: A rising edge on channel 0's output gives a one-clock pulse on irq (IRQ_PULSE=1).
- R7: Mode 2 with reload N: after the load, the output is low after count pulse k exactly when k mod N equals N-1. Otherwise it is high.
- R8: Mode 3 with reload N: the output is high for ceil(N/2) count pulses and low for floor(N/2) count pulses, repeating, starting high after the load.
- R9: While a channel's gate is low, its count and output do not change.
- R10: A count-freeze command (access mode 0) keeps the frozen value until all its bytes are read. Another freeze command issued before then is ignored.
- R11: Read-back command: bit 0 is zero, bits 1, 2 and 3 pick channels 0, 1 and 2, and bit 4 (status) and bit 5 (count) request a freeze when 0. The status byte is {out, null, access[1:0], mode[2:0], bcd}, MSB first. When both are frozen, the status byte is read first.
- R12: A reload value of 0 counts as 65536: the counter loads 0, reads 16'hFFFF after one more pulse, and the mode 0 output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | One-clock count pulse, shared by all channels |
| gate | input | NUM_CH | Per-channel count enable level |
| addr | input | 2 | Register select: channel data 0..2, control 3 |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; advances the byte sequence |
| wdata | input | DATA_W | Write byte |
| rdata | output | DATA_W | Read byte, combinational from addr |
| out | output | NUM_CH | Channel output pins |
| irq | output | 1 | Interrupt request from channel 0 |

## Verification
Read data depends only on addr and registered state, so it is valid in the same cycle as the address. The bench samples it one time step after driving the address, before the edge at which rd_en advances the byte order. Control, data and latch writes take effect at the clock edge where the strobe is sampled. Outputs and counts move at the edge that samples cnt_en, and irq is high for the one cycle after the edge where out[0] rises. All stimulus is driven and all results are sampled on falling clock edges. Every expected count and output level is computed from the number of count pulses applied since the load.

// File: rtl/pit3_pkg.sv
package pit3_pkg;
   typedef enum logic [1:0] {AS_IDLE, AS_WAIT_LO, AS_WAIT_HI, AS_RUN} acc_state_e;
   typedef enum logic [1:0] {AM_LATCH, AM_LO, AM_HI, AM_LOHI} acc_mode_e;

   localparam logic [2:0] MODE_TC   = 3'd0;
   localparam logic [2:0] MODE_RATE = 3'd2;
   localparam logic [2:0] MODE_SQ   = 3'd3;

   // bit 5:4 access, 3:1 mode, 0 bcd: same layout as the low status bits
   typedef struct packed {
      acc_mode_e  acc;
      logic [2:0] mode;
      logic       bcd;
   } chan_cfg_t;
endpackage

// File: rtl/pit3_ctrl_decode.sv
module pit3_ctrl_decode
   import pit3_pkg::*;
#(
   parameter int NUM_CH = 3
) (
   input  logic              wr_ctrl,
   input  logic [7:0]        wdata,
   output logic [NUM_CH-1:0] cfg_wr,
   output logic [NUM_CH-1:0] cnt_latch,
   output logic [NUM_CH-1:0] sts_latch,
   output chan_cfg_t         cfg_in
);
   logic [1:0] sel;
   logic       is_rdbk;

   assign sel     = wdata[7:6];
   assign is_rdbk = (sel == 2'd3);
   assign cfg_in  = chan_cfg_t'(wdata[5:0]);

   always_comb begin
      cfg_wr    = '0;
      cnt_latch = '0;
      sts_latch = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (wr_ctrl) begin
            if (is_rdbk) begin
               if (wdata[i+1]) begin
                  cnt_latch[i] = ~wdata[5];
                  sts_latch[i] = ~wdata[4];
               end
            end else if (sel == 2'(i)) begin
               if (wdata[5:4] == 2'b00) cnt_latch[i] = 1'b1;
               else                     cfg_wr[i]    = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/pit3_channel.sv
module pit3_channel
   import pit3_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_en,
   input  logic              gate,
   input  logic              cfg_wr,
   input  chan_cfg_t         cfg_in,
   input  logic              cnt_latch,
   input  logic              sts_latch,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              data_rd,
   output logic [DATA_W-1:0] rdata,
   output logic              out
);
   localparam int CNT_W = 2 * DATA_W;
   localparam logic [CNT_W:0] FULL_WRAP = {1'b1, {CNT_W{1'b0}}};

   chan_cfg_t        cfg;
   acc_state_e       astate;
   logic [CNT_W-1:0] reload, counter, cnt_hold;
   logic [DATA_W-1:0] sts_hold;
   logic             active, pending, null_cnt, out_q;
   logic             cnt_held, sts_held, rd_hi;

   logic [CNT_W:0]   full_n;
   logic [CNT_W-1:0] hi_half, lo_raw, lo_half;
   logic             tick;
   logic [DATA_W-1:0] status_now;

   assign full_n     = (reload == '0) ? FULL_WRAP : {1'b0, reload};
   assign hi_half    = CNT_W'((full_n + 1'b1) >> 1);
   assign lo_raw     = CNT_W'(full_n >> 1);
   assign lo_half    = (lo_raw == '0) ? CNT_W'(1) : lo_raw;
   assign tick       = cnt_en && gate && active && !pending;
   assign status_now = {out_q, null_cnt, cfg};
   assign out        = out_q;

   function automatic logic [DATA_W-1:0] pick_byte(input logic [CNT_W-1:0] v,
                                                   input acc_mode_e a,
                                                   input logic hi);
      case (a)
         AM_HI:   return v[CNT_W-1:DATA_W];
         AM_LOHI: return hi ? v[CNT_W-1:DATA_W] : v[DATA_W-1:0];
         default: return v[DATA_W-1:0];
      endcase
   endfunction

   assign rdata = sts_held ? sts_hold
                           : pick_byte(cnt_held ? cnt_hold : counter, cfg.acc, rd_hi);

   // configuration, reload writes and counting
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg      <= '0;
         astate   <= AS_IDLE;
         reload   <= '0;
         counter  <= '0;
         active   <= 1'b0;
         pending  <= 1'b0;
         null_cnt <= 1'b0;
         out_q    <= 1'b0;
      end else if (cfg_wr) begin
         cfg     <= cfg_in;
         astate  <= (cfg_in.acc == AM_HI) ? AS_WAIT_HI : AS_WAIT_LO;
         active  <= 1'b0;
         pending <= 1'b0;
         out_q   <= (cfg_in.mode != MODE_TC);
      end else if (data_wr && astate != AS_IDLE) begin
         if (cfg.acc == AM_LOHI && astate != AS_WAIT_HI) begin
            reload[DATA_W-1:0] <= wdata;
            astate             <= AS_WAIT_HI;
         end else begin
            case (cfg.acc)
               AM_LO:   reload <= {{DATA_W{1'b0}}, wdata};
               AM_HI:   reload <= {wdata, {DATA_W{1'b0}}};
               default: reload[CNT_W-1:DATA_W] <= wdata;
            endcase
            astate   <= (cfg.acc == AM_LOHI) ? AS_WAIT_LO : AS_RUN;
            pending  <= 1'b1;
            null_cnt <= 1'b1;
            if (cfg.mode == MODE_TC) out_q <= 1'b0;
         end
      end else if (cnt_en && pending) begin
         counter  <= (cfg.mode == MODE_SQ) ? hi_half : reload;
         pending  <= 1'b0;
         null_cnt <= 1'b0;
         active   <= 1'b1;
      end else if (tick) begin
         case (cfg.mode)
            MODE_TC: begin
               counter <= counter - 1'b1;
               if (counter == CNT_W'(1)) out_q <= 1'b1;
            end
            MODE_RATE: begin
               if (counter == CNT_W'(1)) begin
                  counter <= reload;
                  out_q   <= 1'b1;
               end else begin
                  counter <= counter - 1'b1;
                  if (counter == CNT_W'(2)) out_q <= 1'b0;
               end
            end
            MODE_SQ: begin
               if (counter == CNT_W'(1)) begin
                  out_q   <= ~out_q;
                  counter <= out_q ? lo_half : hi_half;
               end else begin
                  counter <= counter - 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   // latches and read byte order
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_hold <= '0;
         sts_hold <= '0;
         cnt_held <= 1'b0;
         sts_held <= 1'b0;
         rd_hi    <= 1'b0;
      end else if (cfg_wr) begin
         cnt_held <= 1'b0;
         sts_held <= 1'b0;
         rd_hi    <= 1'b0;
      end else begin
         if (sts_latch && !sts_held) begin
            sts_hold <= status_now;
            sts_held <= 1'b1;
         end
         if (cnt_latch && !cnt_held) begin
            cnt_hold <= counter;
            cnt_held <= 1'b1;
         end
         if (data_rd) begin
            if (sts_held) begin
               sts_held <= 1'b0;
            end else begin
               if (cfg.acc == AM_LOHI) rd_hi <= ~rd_hi;
               if (cnt_held && (cfg.acc != AM_LOHI || rd_hi)) cnt_held <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/pit3_timer.sv
module pit3_timer
   import pit3_pkg::*;
#(
   parameter int NUM_CH    = 3,
   parameter int DATA_W    = 8,
   parameter bit IRQ_PULSE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_en,
   input  logic [NUM_CH-1:0] gate,
   input  logic [1:0]        addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [NUM_CH-1:0] out,
   output logic              irq
);
   localparam logic [1:0] CTRL_ADDR = 2'd3;

   if (NUM_CH < 1 || NUM_CH > 3) begin : g_bad_nch
      $error("pit3_timer: NUM_CH must be 1..3");
   end
   if (DATA_W != 8) begin : g_bad_dw
      $error("pit3_timer: DATA_W must be 8");
   end

   logic [NUM_CH-1:0] cfg_wr, cnt_latch, sts_latch;
   chan_cfg_t         cfg_in;
   logic [DATA_W-1:0] ch_rdata [NUM_CH];

   pit3_ctrl_decode #(.NUM_CH(NUM_CH)) u_dec (
      .wr_ctrl   (wr_en && addr == CTRL_ADDR),
      .wdata     (wdata),
      .cfg_wr    (cfg_wr),
      .cnt_latch (cnt_latch),
      .sts_latch (sts_latch),
      .cfg_in    (cfg_in)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      pit3_channel #(.DATA_W(DATA_W)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .cnt_en    (cnt_en),
         .gate      (gate[g]),
         .cfg_wr    (cfg_wr[g]),
         .cfg_in    (cfg_in),
         .cnt_latch (cnt_latch[g]),
         .sts_latch (sts_latch[g]),
         .data_wr   (wr_en && addr == 2'(g)),
         .wdata     (wdata),
         .data_rd   (rd_en && addr == 2'(g)),
         .rdata     (ch_rdata[g]),
         .out       (out[g])
      );
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_CH; i++)
         if (addr == 2'(i)) rdata = ch_rdata[i];
   end

   if (IRQ_PULSE) begin : g_irq_pulse
      logic out0_q;
      always_ff @(posedge clk) begin
         if (!rst_n) out0_q <= 1'b0;
         else        out0_q <= out[0];
      end
      assign irq = out[0] & ~out0_q;
   end else begin : g_irq_level
      assign irq = out[0];
   end
endmodule

// File: rtl/pit3_checker.sv
module pit3_checker #(
   parameter int NUM_CH    = 3,
   parameter int DATA_W    = 8,
   parameter bit IRQ_PULSE = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        addr,
   input logic              wr_en,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic [NUM_CH-1:0] gate,
   input logic [NUM_CH-1:0] out,
   input logic              irq
);
   p_ctrl_read_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == 2'd3) |-> (rdata == '0));

   p_irq_from_ch0_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> out[0]);

   if (IRQ_PULSE) begin : g_pulse_chk
      p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
         irq |=> !irq);
   end

   for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
      p_cfg_mode0_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && addr == 2'd3 && wdata[7:6] == 2'(g) && wdata[5:4] != 2'd0
          && wdata[3:1] == 3'd0) |=> !out[g]);
      p_cfg_other_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && addr == 2'd3 && wdata[7:6] == 2'(g) && wdata[5:4] != 2'd0
          && wdata[3:1] != 3'd0) |=> out[g]);
      p_gate_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (!gate[g] && !wr_en) |=> $stable(out[g]));
   end
endmodule

bind pit3_timer pit3_checker #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .IRQ_PULSE(IRQ_PULSE)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .addr  (addr),
   .wr_en (wr_en),
   .wdata (wdata),
   .rdata (rdata),
   .gate  (gate),
   .out   (out),
   .irq   (irq)
);

// File: tb/pit3_timer_tb.sv
module pit3_timer_tb_top;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cnt_en = 1'b0;
   logic [2:0] gate = 3'b111;
   logic [1:0] addr = 2'd0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic [2:0] out;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   pit3_timer dut_i (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .gate(gate), .addr(addr),
      .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
      .out(out), .irq(irq)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic rd16(input logic [1:0] a, output int v);
      logic [7:0] lo, hi;
      rd(a, lo);
      rd(a, hi);
      v = {16'h0, hi, lo};
   endtask

   task automatic tick();
      @(negedge clk);
      cnt_en = 1'b1;
      @(negedge clk);
      cnt_en = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   function automatic int exp_rate(input int n, input int k);
      return ((k % n) == n - 1) ? 0 : 1;
   endfunction

   function automatic int exp_square(input int n, input int k);
      return ((k % n) >= (n + 1) / 2) ? 0 : 1;
   endfunction

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] b;
      int v;
      int n, k;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      check("R1 reset out", out, 0);
      check("R6 reset irq", irq, 0);
      rd(2'd3, b);
      check("R1 control read", b, 8'h00);

      // R2: write to unconfigured channel ignored
      wr(2'd2, 8'h55);
      tick();
      rd(2'd2, b);
      check("R2 unconfigured write", b, 8'h00);

      // ch0 mode 0 low-then-high, N=10
      wr(2'd3, 8'h30);
      check("R3 mode0 low", out[0], 0);
      wr(2'd0, 8'd10);
      wr(2'd0, 8'd0);
      wr(2'd3, 8'hE2);
      rd(2'd0, b);
      check("R4 R11 status null set", b, 8'h70);
      tick();
      wr(2'd3, 8'hE2);
      rd(2'd0, b);
      check("R4 status null cleared", b, 8'h30);
      ticks(9);
      check("R5 low before TC", out[0], 0);
      tick();
      check("R5 high at TC", out[0], 1);
      check("R6 irq pulse", irq, 1);
      @(negedge clk);
      check("R6 irq single", irq, 0);
      ticks(5);
      check("R5 stays high", out[0], 1);

      // ch1 mode 0 N=1000, count freeze
      wr(2'd3, 8'h70);
      wr(2'd1, 8'hE8);
      wr(2'd1, 8'h03);
      tick();
      ticks(5);
      wr(2'd3, 8'h40);
      ticks(7);
      wr(2'd3, 8'h40);
      rd16(2'd1, v);
      check("R10 frozen count", v, 995);
      rd16(2'd1, v);
      check("R10 live after release", v, 988);

      // gate pause
      gate[1] = 1'b0;
      ticks(20);
      rd16(2'd1, v);
      check("R9 gate hold count", v, 988);
      check("R9 gate hold out", out[1], 0);
      gate[1] = 1'b1;

      // read-back status and count ch1
      wr(2'd3, 8'hC4);
      ticks(3);
      rd(2'd1, b);
      check("R11 status first", b, 8'h30);
      rd16(2'd1, v);
      check("R11 frozen count", v, 988);
      rd16(2'd1, v);
      check("R11 live count", v, 985);

      // ch2 bcd flag, mode 2, low only
      wr(2'd3, 8'h95);
      check("R3 mode2 high", out[2], 1);
      wr(2'd3, 8'hE8);
      rd(2'd2, b);
      check("R1 R11 status layout", b, 8'h95);

      // R7 mode 2 directed N=5 then random
      wr(2'd2, 8'd5);
      tick();
      for (int i = 1; i <= 15; i++) begin
         tick();
         check("R7 rate N=5", out[2], exp_rate(5, i));
      end
      for (int r = 0; r < 3; r++) begin
         n = $urandom_range(12, 2);
         wr(2'd3, 8'h94);
         wr(2'd2, 8'(n));
         tick();
         for (int i = 1; i <= 2 * n; i++) begin
            tick();
            check("R7 rate random", out[2], exp_rate(n, i));
         end
      end

      // R8 mode 3 directed odd/even then random
      for (int r = 0; r < 5; r++) begin
         n = (r == 0) ? 7 : (r == 1) ? 6 : $urandom_range(20, 2);
         wr(2'd3, 8'hB6);
         check("R3 mode3 high", out[2], 1);
         wr(2'd2, 8'(n));
         wr(2'd2, 8'h00);
         tick();
         for (int i = 1; i <= 3 * n; i++) begin
            tick();
            check("R8 square", out[2], exp_square(n, i));
         end
      end

      // R12 reload of zero
      wr(2'd3, 8'h70);
      wr(2'd1, 8'h00);
      wr(2'd1, 8'h00);
      tick();
      rd16(2'd1, v);
      check("R12 zero loaded", v, 0);
      tick();
      rd16(2'd1, v);
      check("R12 wraps", v, 16'hFFFF);
      check("R12 out low", out[1], 0);

      // R2 low-only and high-only
      wr(2'd3, 8'h50);
      wr(2'd1, 8'h34);
      tick();
      rd(2'd1, b);
      check("R2 low only", b, 8'h34);
      wr(2'd3, 8'h60);
      wr(2'd1, 8'h12);
      tick();
      rd(2'd1, b);
      check("R2 high only", b, 8'h12);
      tick();
      rd(2'd1, b);
      check("R2 high only after pulse", b, 8'h11);

      // random mode 0 counts
      for (int r = 0; r < 6; r++) begin
         n = $urandom_range(5000, 60);
         k = $urandom_range(40, 1);
         wr(2'd3, 8'h70);
         wr(2'd1, 8'(n));
         wr(2'd1, 8'(n >> 8));
         tick();
         ticks(k);
         wr(2'd3, 8'h40);
         rd16(2'd1, v);
         check("R5 R10 random count", v, n - k);
         check("R5 random out low", out[1], 0);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule